// File: doc/BRIEF.md
# Reversible Gate Cascade Evaluator

This block runs a stored list of reversible multiple-control inverter gates over an 8-line bit vector. Each gate in the list has three fields. The first is a set of lines that must read 1. The second is a set of lines that must read 0. The third is the index of the one line that the gate flips when both conditions hold. A gate with no conditioning lines always flips its target. Every line other than the target passes through the gate unchanged. Line k of the vector is bit k of every vector port.

Software fills the gate list through a write port. A caller then presents an input vector and a gate count, and pulses `start`. The block applies gates 0, 1, 2 and onward in that order, one gate per clock. When it finishes it raises `done` for one cycle. It then presents the final vector, a per-gate flag showing which gates flipped their target, and the number of gates that flipped.

A well-formed gate list gives a bijection on the vector space, so the block can also be used to check that a list of gates implements an intended permutation.

Top module: `revc_cascade`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `vec_out`, `fired` and `fire_cnt` all read zero, and every table entry is cleared to zero.
- R2: A gate flips its target line only when every line in its positive mask is 1 and every line in its negative mask is 0. When it flips, no other line changes. When it does not flip, the vector passes through unchanged. For example, take a gate with target bit 0 and positive mask 8'b0000_1100. Given the input 8'b0000_0010, this gate leaves the vector as it is.
- R3: A gate whose positive and negative masks are both zero always flips its target line.
- R4: Gates 0 through count-1 are applied in ascending order, one per clock. `done` is high after the (count+1)-th rising edge, counting the edge that samples `start` as the first. With a count of 0, `vec_out` equals `vec_in`.
- R5: A gate that has any line set in both its positive and negative masks never flips.
- R6: A gate whose target line appears in either of its masks never flips.
- R7: Bit i of `fired` is 1 exactly when gate i flipped its target during the last evaluation. Bits at index count and above read 0. `fire_cnt` equals the number of set bits in `fired`. Both are cleared when a new evaluation is accepted.
- R8: A requested count above 32 is treated as 32, so `fire_cnt` never exceeds 32.
- R9: A `start` pulse that arrives while `busy` is high is ignored. It produces no extra `done` and does not change the result.
- R10: `done` is high for exactly one cycle. After that, `vec_out`, `fired` and `fire_cnt` hold their values until the next accepted `start`.
- R11: With a well-formed table and a fixed count, distinct input vectors always produce distinct output vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Writes one gate table entry |
| wr_addr | input | 5 | Index of the table entry to write |
| wr_pos | input | 8 | Positive-control mask: these lines must read 1 |
| wr_neg | input | 8 | Negative-control mask: these lines must read 0 |
| wr_tgt | input | 3 | Index of the target line |
| start | input | 1 | Begins an evaluation when the block is idle |
| gate_count | input | 6 | Number of gates to apply, sampled at start |
| vec_in | input | 8 | Input vector, sampled at start |
| busy | output | 1 | An evaluation is in progress |
| done | output | 1 | One-cycle strobe marking that the result is ready |
| vec_out | output | 8 | Final vector |
| fired | output | 32 | Per-gate flag showing that the gate flipped its target |
| fire_cnt | output | 6 | Number of gates that flipped their target |

## Verification
The assertions assume that the gate table is not rewritten while `busy` is high. They also assume that `start` is one cycle wide whenever the block is idle. Otherwise the hold and clear properties would describe a different evaluation from the one in progress. The stimulus writes the table only between runs. It raises `start` for a single cycle, at the falling edge. It pulses `start` during `busy` only on purpose, to test that such a pulse is ignored. Requested counts range from 0 to above the table depth, and the tables include malformed gates whose masks overlap each other or contain the target line.

// File: rtl/revc_pkg.sv
package revc_pkg;
    localparam int LINES  = 8;
    localparam int TDEPTH = 32;
    localparam int TGT_W  = $clog2(LINES);
    localparam int ADDR_W = $clog2(TDEPTH);
    localparam int CNT_W  = $clog2(TDEPTH + 1);

    typedef logic [LINES-1:0]  lvec_t;
    typedef logic [TDEPTH-1:0] fvec_t;

    typedef struct packed {
        lvec_t            pos_m;
        lvec_t            neg_m;
        logic [TGT_W-1:0] tgt;
    } gate_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } st_t;

    // A gate is well formed when no line is both a 1-control and a
    // 0-control and when its target is not one of its own controls.
    function automatic logic gate_ok(gate_t g);
        return ((g.pos_m & g.neg_m) == '0) && !g.pos_m[g.tgt] && !g.neg_m[g.tgt];
    endfunction

    function automatic logic gate_hit(gate_t g, lvec_t v);
        return gate_ok(g) && ((v & g.pos_m) == g.pos_m) && ((v & g.neg_m) == '0);
    endfunction

    function automatic logic [CNT_W-1:0] clamp_cnt(logic [CNT_W-1:0] c);
        return (c > CNT_W'(TDEPTH)) ? CNT_W'(TDEPTH) : c;
    endfunction
endpackage

// File: rtl/revc_table.sv
module revc_table
    import revc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  gate_t             wr_gate,
    input  logic [ADDR_W-1:0] rd_addr,
    output gate_t             rd_gate
);
    gate_t mem [TDEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < TDEPTH; e++) begin
                mem[e] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_gate;
        end
    end

    assign rd_gate = mem[rd_addr];
endmodule

// File: rtl/revc_stage.sv
module revc_stage
    import revc_pkg::*;
(
    input  gate_t g,
    input  lvec_t vin,
    output lvec_t vout,
    output logic  hit
);
    lvec_t flip_m;

    always_comb begin
        hit    = gate_hit(g, vin);
        flip_m = '0;
        for (int k = 0; k < LINES; k++) begin
            flip_m[k] = hit && (g.tgt == TGT_W'(k));
        end
        vout = vin ^ flip_m;
    end
endmodule

// File: rtl/revc_seq.sv
module revc_seq
    import revc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_req,
    input  lvec_t             vec_in,
    input  lvec_t             stage_vout,
    input  logic              stage_hit,
    output logic [ADDR_W-1:0] gate_idx,
    output lvec_t             vec_cur,
    output logic              busy,
    output logic              done,
    output fvec_t             fired,
    output logic [CNT_W-1:0]  fire_cnt
);
    st_t              state;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] eff_req;
    logic             at_last;

    assign eff_req  = clamp_cnt(cnt_req);
    assign at_last  = (CNT_W'(gate_idx) + CNT_W'(1)) == last;
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            gate_idx <= '0;
            last     <= '0;
            vec_cur  <= '0;
            fired    <= '0;
            fire_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        vec_cur  <= vec_in;
                        fired    <= '0;
                        fire_cnt <= '0;
                        gate_idx <= '0;
                        last     <= eff_req;
                        state    <= (eff_req == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    vec_cur         <= stage_vout;
                    fired[gate_idx] <= stage_hit;
                    fire_cnt        <= fire_cnt + CNT_W'(stage_hit);
                    if (at_last) begin
                        state <= ST_FIN;
                    end else begin
                        gate_idx <= gate_idx + ADDR_W'(1);
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/revc_cascade.sv
module revc_cascade
    import revc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [LINES-1:0]       wr_pos,
    input  logic [LINES-1:0]       wr_neg,
    input  logic [TGT_W-1:0]       wr_tgt,
    input  logic                   start,
    input  logic [CNT_W-1:0]       gate_count,
    input  logic [LINES-1:0]       vec_in,
    output logic                   busy,
    output logic                   done,
    output logic [LINES-1:0]       vec_out,
    output logic [TDEPTH-1:0]      fired,
    output logic [CNT_W-1:0]       fire_cnt
);
    gate_t             wr_gate;
    gate_t             cur_gate;
    logic [ADDR_W-1:0] gate_idx;
    lvec_t             stage_vout;
    logic              stage_hit;

    assign wr_gate = '{pos_m: wr_pos, neg_m: wr_neg, tgt: wr_tgt};

    revc_table u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_gate (wr_gate),
        .rd_addr (gate_idx),
        .rd_gate (cur_gate)
    );

    revc_stage u_stage (
        .g    (cur_gate),
        .vin  (vec_out),
        .vout (stage_vout),
        .hit  (stage_hit)
    );

    revc_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cnt_req    (gate_count),
        .vec_in     (vec_in),
        .stage_vout (stage_vout),
        .stage_hit  (stage_hit),
        .gate_idx   (gate_idx),
        .vec_cur    (vec_out),
        .busy       (busy),
        .done       (done),
        .fired      (fired),
        .fire_cnt   (fire_cnt)
    );
endmodule

// File: rtl/revc_checker.sv
module revc_checker
    import revc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [LINES-1:0]  vec_out,
    input logic [TDEPTH-1:0] fired,
    input logic [CNT_W-1:0]  fire_cnt
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(vec_out) && $stable(fired) && $stable(fire_cnt))); // R10

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R9

    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R9

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fire_cnt <= CNT_W'(TDEPTH)); // R8

    AST_CNT_MATCHES_FLAGS: assert property (@(posedge clk) disable iff (rst)
        done |-> (32'(fire_cnt) == 32'($countones(fired)))); // R7

    AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !done) |-> (fire_cnt == '0 && fired == '0)); // R7
endmodule

bind revc_cascade revc_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .vec_out  (vec_out),
    .fired    (fired),
    .fire_cnt (fire_cnt)
);

// File: tb/test_revc_cascade.sv
module test_revc_cascade;
    import revc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [LINES-1:0]  wr_pos = '0;
    logic [LINES-1:0]  wr_neg = '0;
    logic [TGT_W-1:0]  wr_tgt = '0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  gate_count = '0;
    logic [LINES-1:0]  vec_in = '0;
    logic              busy, done;
    logic [LINES-1:0]  vec_out;
    logic [TDEPTH-1:0] fired;
    logic [CNT_W-1:0]  fire_cnt;

    always #10 clk = ~clk;

    revc_cascade i_revc_cascade (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_pos(wr_pos), .wr_neg(wr_neg), .wr_tgt(wr_tgt),
        .start(start), .gate_count(gate_count), .vec_in(vec_in),
        .busy(busy), .done(done), .vec_out(vec_out),
        .fired(fired), .fire_cnt(fire_cnt)
    );

    typedef struct {
        logic [LINES-1:0]  v;
        logic [TDEPTH-1:0] f;
        int                c;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;
    logic prev_done = 1'b0;

    logic [LINES-1:0] tb_pos [TDEPTH];
    logic [LINES-1:0] tb_neg [TDEPTH];
    logic [TGT_W-1:0] tb_tgt [TDEPTH];

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model built from the requirements (R2, R3, R5, R6, R7, R8).
    task automatic model(input int cnt, input logic [LINES-1:0] vin,
                         output logic [LINES-1:0] vout, output logic [TDEPTH-1:0] f, output int c);
        int eff = (cnt > TDEPTH) ? TDEPTH : cnt;
        vout = vin; f = '0; c = 0;
        for (int i = 0; i < eff; i++) begin
            logic ok, hit;
            ok  = ((tb_pos[i] & tb_neg[i]) == '0) && !tb_pos[i][tb_tgt[i]] && !tb_neg[i][tb_tgt[i]];
            hit = ok && ((vout & tb_pos[i]) == tb_pos[i]) && ((vout & tb_neg[i]) == '0);
            if (hit) vout[tb_tgt[i]] = ~vout[tb_tgt[i]];
            f[i] = hit;
            c += int'(hit);
        end
    endtask

    task automatic load_gate(input int a, input logic [LINES-1:0] p, input logic [LINES-1:0] n, input int t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_pos = p; wr_neg = n; wr_tgt = TGT_W'(t);
        tb_pos[a] = p; tb_neg[a] = n; tb_tgt[a] = TGT_W'(t);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: pushes the expected result, pulses start, checks latency (R4).
    task automatic run_eval(input int cnt, input logic [LINES-1:0] vin, input string tag,
                            output logic [LINES-1:0] vexp);
        exp_t e;
        int   k = 0;
        int   eff = (cnt > TDEPTH) ? TDEPTH : cnt;
        model(cnt, vin, e.v, e.f, e.c);
        e.tag = tag;
        vexp = e.v;
        q.push_back(e);
        @(negedge clk);
        start = 1'b1; gate_count = CNT_W'(cnt); vec_in = vin;
        do begin
            @(negedge clk);
            start = 1'b0;
            k++;
        end while (!done && k < 100);
        check(k == eff + 1, "R4 done latency", k, eff + 1);
        @(negedge clk);
    endtask

    // Monitor: pops expected items when done is seen.
    always @(negedge clk) begin
        if (!rst) begin
            if (done && prev_done) check(0, "R10 done longer than one cycle", 1, 0);
            if (done) begin
                if (q.size() == 0) begin
                    check(0, "R9 done without accepted start", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(vec_out == e.v, {e.tag, " R2 vec_out"}, vec_out, e.v);
                    check(fired == e.f, {e.tag, " R7 fired"}, fired, e.f);
                    check(int'(fire_cnt) == e.c, {e.tag, " R7 fire_cnt"}, fire_cnt, e.c);
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [LINES-1:0] vx;
        bit               seen [256];
        for (int i = 0; i < TDEPTH; i++) begin
            tb_pos[i] = '0; tb_neg[i] = '0; tb_tgt[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(vec_out == '0, "R1 vec_out after reset", vec_out, 0);
        check(fired == '0, "R1 fired after reset", fired, 0);
        check(fire_cnt == '0, "R1 fire_cnt after reset", fire_cnt, 0);
        // R1: cleared table entry 0 has empty controls, so it flips bit 0
        run_eval(1, 8'h00, "R1 cleared table", vx);

        // R2: target bit 0, positive controls on bits 2 and 3
        load_gate(0, 8'b0000_1100, 8'h00, 0);
        run_eval(1, 8'b0000_0010, "R2 example no flip", vx);
        check(vx == 8'b0000_0010, "R2 model example", vx, 8'h02);
        run_eval(1, 8'b0000_1110, "R2 controls met", vx);
        // R2 negative controls
        load_gate(0, 8'b0001_0000, 8'b0100_0000, 5);
        run_eval(1, 8'b0001_0000, "R2 mixed polarity fire", vx);
        run_eval(1, 8'b0101_0000, "R2 mixed polarity block", vx);
        // R3: empty control set
        load_gate(0, 8'h00, 8'h00, 7);
        run_eval(1, 8'h5A, "R3 empty controls", vx);
        check(vx == 8'hDA, "R3 model flip", vx, 8'hDA);
        // R5: overlapping masks
        load_gate(0, 8'b0000_0011, 8'b0000_0010, 4);
        run_eval(1, 8'b0000_0011, "R5 overlap masks", vx);
        // R6: target inside its own masks
        load_gate(0, 8'b0000_0101, 8'h00, 0);
        run_eval(1, 8'b0000_0101, "R6 target in positive mask", vx);
        load_gate(0, 8'h00, 8'b0000_0001, 0);
        run_eval(1, 8'b0000_0000, "R6 target in negative mask", vx);

        // Full table with a mix of gate kinds (R2, R3, R5, R6)
        for (int i = 0; i < TDEPTH; i++) begin
            logic [LINES-1:0] tb_bit, p, n;
            int t = (i * 3 + 1) % LINES;
            tb_bit = LINES'(1) << t;
            p = (LINES'(1) << ((i + 3) % LINES)) & ~tb_bit;
            n = (LINES'(1) << ((i * 5 + 2) % LINES)) & ~tb_bit & ~p;
            if (i == 4)  begin p = '0; n = '0; end
            if (i == 9)  n = n | p;
            if (i == 13) p = p | tb_bit;
            load_gate(i, p, n, t);
        end
        run_eval(32, 8'hA5, "R4 full table A5", vx);
        run_eval(32, 8'h3C, "R4 full table 3C", vx);
        run_eval(10, 8'hFF, "R7 partial count", vx);
        run_eval(0, 8'h77, "R4 zero count", vx);
        check(vx == 8'h77, "R4 zero count passes input", vx, 8'h77);
        run_eval(50, 8'h12, "R8 count above depth", vx);

        // R10: result holds while idle
        repeat (4) @(negedge clk);
        check(vec_out == vx, "R10 vec_out holds", vec_out, vx);

        // R9: start pulse during busy is ignored
        begin
            exp_t e;
            int   k = 0;
            model(32, 8'h81, e.v, e.f, e.c);
            e.tag = "R9 ignored start";
            q.push_back(e);
            @(negedge clk);
            start = 1'b1; gate_count = 6'd32; vec_in = 8'h81;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            start = 1'b1; gate_count = 6'd3; vec_in = 8'h00;
            @(negedge clk);
            start = 1'b0;
            while (busy && k < 100) begin
                @(negedge clk);
                k++;
            end
            repeat (3) @(negedge clk);
            check(q.size() == 0 && !busy, "R9 single result", q.size(), 0);
            check(vec_out == e.v, "R9 result unchanged", vec_out, e.v);
        end

        // R11: all inputs through the full table give distinct outputs
        for (int i = 0; i < TDEPTH; i++) begin
            logic [LINES-1:0] tb_bit;
            int t = (i * 5 + 2) % LINES;
            tb_bit = LINES'(1) << t;
            load_gate(i, (LINES'(1) << ((i + 1) % LINES)) & ~tb_bit,
                         (LINES'(1) << ((i + 6) % LINES)) & ~tb_bit & ~(LINES'(1) << ((i + 1) % LINES)), t);
        end
        for (int v = 0; v < 256; v++) seen[v] = 0;
        for (int v = 0; v < 256; v++) begin
            run_eval(32, LINES'(v), "R11 sweep", vx);
            check(!seen[vec_out], "R11 distinct output", vec_out, v);
            seen[vec_out] = 1;
        end

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule